// File: doc/BRIEF.md
# Error-Driven Byte Alignment Unit

This unit restores octet boundaries in a byte stream that was packed from a serial line and may therefore start at any bit position. Each incoming byte is joined to the byte before it, and an 8-bit slice of that 16-bit window is sent on, taken at the currently selected bit offset. Bits are treated as most significant first. An offset of zero passes the input byte through unchanged.

The offset is not found by searching for a pattern. Downstream framing and checksum logic report each completed frame and whether it was bad. The unit keeps a sliding record of the most recent frame outcomes. When too many of them are bad, it moves one bit further along. A single-cycle request can also move it straight away. After every move there is a hold-off period, so that the new offset gets a fair trial before errors can move it again. When alignment is disabled, the stream passes through with no shift and every request and error report is ignored.

Top module: `byte_align_unit`

## Requirements
- R1: While `align_en` is 0, each byte taken with `in_valid` appears unchanged on `out_byte` one clock later, and `offset` reads 0.
- R2: `out_valid` follows `in_valid` one clock later. With offset k, `out_byte` equals bits [7+k:k] of {previous valid byte, current byte}. The previous byte is held across cycles with no valid input.
- R3: While enabled, a cycle with `realign_req` high advances the offset by one on the next clock edge, and offset 7 wraps to 0.
- R4: While disabled, `realign_req` has no effect. The stored offset is kept and appears again on `offset` once `align_en` returns to 1.
- R5: Once the hold-off has passed, the offset advances by one when more than 4 of the last 16 reported frames were errored. The new offset is visible after the second clock edge that follows the `frame_done` cycle which pushed the count over the limit.
- R6: When at most 4 of the last 16 reported frames were errored, error reports never move the offset. Errors older than 16 frames no longer count.
- R7: Until 16 frames have been reported since the last offset change, error reports cannot move the offset.
- R8: Every offset change clears the error record and restarts the hold-off, so a burst of errors cannot cause back-to-back moves.
- R9: Frame reports received while disabled have no effect. Enabling starts a fresh hold-off with an empty error record.
- R10: After reset, `offset`, `out_byte` and `out_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte | input | 8 | Incoming byte, possibly misaligned |
| in_valid | input | 1 | `in_byte` is valid this cycle |
| align_en | input | 1 | 1 enables offset search and shifting; 0 passes the stream through |
| realign_req | input | 1 | Single-cycle request to step to the next offset |
| frame_done | input | 1 | A downstream frame finished this cycle |
| frame_err | input | 1 | That frame was bad (sampled together with `frame_done`) |
| out_byte | output | 8 | Re-aligned byte |
| out_valid | output | 1 | `out_byte` is valid |
| offset | output | 3 | Bit offset in use (0 while disabled) |

## Verification
The hardest state to reach is an error-triggered move that happens only at the exact frame where the hold-off expires, or where an old error drops out of the sliding window. A move triggered at the wrong frame looks just like a correct one unless the frame count is exact. The bench therefore drives frame reports one at a time. It places the error frames so that the window holds exactly 4 errors and then exactly 5, and so that 15 and then 16 frames have passed since a move. It checks the offset two clocks after each chosen frame. It also toggles `align_en` partway through to show that the error record and hold-off restart.

// File: rtl/byte_align_pkg.sv
// Shared constants for the byte alignment unit.
// Assumes byte-wide data, most significant bit first on the line.
package byte_align_pkg;
    localparam int BYTE_W      = 8;
    localparam int OFF_W       = $clog2(BYTE_W);
    localparam int WIN_FRAMES  = 16;
    localparam int ERR_LIMIT   = 4;
    localparam int HOLD_FRAMES = 16;
endpackage

// File: rtl/align_shifter.sv
// Barrel re-assembly of the byte stream at a chosen bit offset.
// Keeps the previous valid byte and emits a slice of the 2-byte window,
// registered, one cycle after each valid input. Assumes shift < W.
module align_shifter #(
    parameter int W     = 8,
    parameter int OFF_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     in_byte,
    input  logic             in_valid,
    input  logic [OFF_W-1:0] shift,
    output logic [W-1:0]     out_byte,
    output logic             out_valid
);
    localparam int WIN_W = 2 * W;

    logic [W-1:0]     prev_q;
    logic [WIN_W-1:0] window;
    logic [W-1:0]     cand [W];

    assign window = {prev_q, in_byte};

    // One candidate slice per possible offset.
    for (genvar g = 0; g < W; g++) begin : g_cand
        assign cand[g] = window[g+W-1:g];
    end

    // Register the selected slice and remember the latest valid byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            out_byte  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prev_q   <= in_byte;
                out_byte <= cand[shift];
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid)); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_byte)); // R2
endmodule

// File: rtl/align_monitor.sv
// Offset selection driven by the downstream error rate.
// Records the outcome of the last WIN frames. Once HOLD frames have passed
// since the last move, it steps the offset when more than LIMIT of them were
// bad. A realign request steps the offset at once. Every move clears the
// record. Assumes frame_err is only meaningful together with frame_done.
module align_monitor #(
    parameter int OFF_W = 3,
    parameter int WIN   = 16,
    parameter int LIMIT = 4,
    parameter int HOLD  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             align_en,
    input  logic             realign_req,
    input  logic             frame_done,
    input  logic             frame_err,
    output logic [OFF_W-1:0] off_q
);
    localparam int CNT_W  = $clog2(WIN + 1);
    localparam int HOLD_W = $clog2(HOLD + 1);

    logic [WIN-1:0]    hist;
    logic [HOLD_W-1:0] hold_cnt;
    logic [CNT_W-1:0]  err_cnt;
    logic              hold_done;
    logic              trip;
    logic              step;

    // Count errors in the window and decide whether to move.
    always_comb begin
        err_cnt   = CNT_W'($countones(hist));
        hold_done = (hold_cnt == HOLD_W'(HOLD));
        trip      = hold_done && (err_cnt > CNT_W'(LIMIT));
        step      = align_en && (realign_req || trip);
    end

    // Offset register, error history and hold-off counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= '0;
            hist     <= '0;
            hold_cnt <= '0;
        end else if (!align_en) begin
            hist     <= '0;
            hold_cnt <= '0;
        end else if (step) begin
            off_q    <= off_q + OFF_W'(1);
            hist     <= '0;
            hold_cnt <= '0;
        end else if (frame_done) begin
            hist <= {hist[WIN-2:0], frame_err};
            if (!hold_done) hold_cnt <= hold_cnt + HOLD_W'(1);
        end
    end

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && off_q != $past(off_q)) |-> off_q == $past(off_q) + OFF_W'(1)); // R3
    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(align_en)) |-> $stable(off_q)); // R4
    AST_HOLDOFF_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && off_q != $past(off_q) && !$past(realign_req)) |-> $past(hold_done)); // R7
    AST_CLEARED_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && off_q != $past(off_q)) |-> (hist == '0 && hold_cnt == '0)); // R8
endmodule

// File: rtl/byte_align_unit.sv
// Top of the byte alignment unit: the error-driven offset selector plus the
// barrel re-assembly path. While disabled, the shift is forced to zero, so
// the stream passes through. The stored offset is kept for later use.
module byte_align_unit
    import byte_align_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              align_en,
    input  logic              realign_req,
    input  logic              frame_done,
    input  logic              frame_err,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_valid,
    output logic [OFF_W-1:0]  offset
);
    logic [OFF_W-1:0] off_q;

    align_monitor #(
        .OFF_W(OFF_W), .WIN(WIN_FRAMES), .LIMIT(ERR_LIMIT), .HOLD(HOLD_FRAMES)
    ) u_monitor (
        .clk(clk), .rst_n(rst_n), .align_en(align_en), .realign_req(realign_req),
        .frame_done(frame_done), .frame_err(frame_err), .off_q(off_q)
    );

    // Effective shift: the stored offset only while alignment is enabled.
    assign offset = align_en ? off_q : '0;

    align_shifter #(.W(BYTE_W), .OFF_W(OFF_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .shift(offset), .out_byte(out_byte), .out_valid(out_valid)
    );

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(align_en) && $past(in_valid)) |-> out_byte == $past(in_byte)); // R1
endmodule

// File: tb/byte_align_unit_bench.sv
`timescale 1ns/1ps
module byte_align_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_valid = 1'b0;
    logic       align_en = 1'b0;
    logic       realign_req = 1'b0;
    logic       frame_done = 1'b0;
    logic       frame_err = 1'b0;
    logic [7:0] out_byte;
    logic       out_valid;
    logic [2:0] offset;

    int checks = 0;
    int failures = 0;
    logic [7:0] m_prev = '0;
    logic [2:0] m_off = '0;

    always #2.5 clk = ~clk;

    byte_align_unit u_byte_align_unit (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
        .align_en(align_en), .realign_req(realign_req), .frame_done(frame_done),
        .frame_err(frame_err), .out_byte(out_byte), .out_valid(out_valid),
        .offset(offset)
    );

    // Stimulus table: {offset to use, byte to send}
    localparam int NV = 12;
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 8'hA5}, {3'd0, 8'h3C}, {3'd1, 8'hF0}, {3'd1, 8'h0F},
        {3'd2, 8'h96}, {3'd3, 8'h01}, {3'd4, 8'h80}, {3'd5, 8'hE7},
        {3'd6, 8'h5A}, {3'd7, 8'hC3}, {3'd0, 8'h7E}, {3'd0, 8'h81}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [2:0] k, input string req);
        logic [15:0] w;
        w = {m_prev, b} >> k;
        @(negedge clk);
        in_byte = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, int'(out_valid), 1);
        chk(req, int'(out_byte), int'(w[7:0]));
        m_prev = b;
        idle(1);
        chk(req, int'(out_valid), 0);
    endtask

    task automatic pulse_realign();
        @(negedge clk);
        realign_req = 1'b1;
        @(negedge clk);
        realign_req = 1'b0;
    endtask

    task automatic frames(input int n, input logic err);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_done = 1'b1; frame_err = err;
            @(negedge clk);
            frame_done = 1'b0; frame_err = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        // R10: reset state
        chk("R10 offset", int'(offset), 0);
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 out_byte", int'(out_byte), 0);
        rst_n = 1'b1;

        // R1: pass-through while disabled
        send_byte(8'h5B, 3'd0, "R1");
        send_byte(8'hC4, 3'd0, "R1");
        chk("R1 offset", int'(offset), 0);

        // R4: realign ignored while disabled; R9: errors ignored while disabled
        pulse_realign();
        frames(20, 1'b1);
        idle(2);
        @(negedge clk); align_en = 1'b1;
        idle(1);
        chk("R4 realign ignored", int'(offset), 0);
        chk("R9 errors ignored", int'(offset), 0);

        // R2/R3: table walk over offsets, including the wrap from 7 to 0
        for (int i = 0; i < NV; i++) begin
            while (m_off != VEC[i][10:8]) begin
                pulse_realign();
                m_off = m_off + 3'd1;
                chk("R3 step", int'(offset), int'(m_off));
            end
            send_byte(VEC[i][7:0], m_off, "R2");
        end
        chk("R3 wrap", int'(offset), 0);

        // R2: previous byte kept across a long idle gap
        idle(5);
        pulse_realign(); m_off = 3'd1;
        idle(4);
        send_byte(8'h42, m_off, "R2 gap");

        // R7: 15 error frames after the last move do not move the offset
        frames(15, 1'b1);
        idle(2);
        chk("R7 hold-off", int'(offset), 1);
        // R5: the 16th frame ends the hold-off with 16 errors, so the offset moves
        frames(1, 1'b1);
        chk("R5 not yet", int'(offset), 1);
        idle(1);
        chk("R5 trip", int'(offset), 2);
        m_off = 3'd2;
        // R8: record cleared, so 15 more error frames do nothing
        frames(15, 1'b1);
        idle(2);
        chk("R8 no back-to-back", int'(offset), 2);

        // R4: disable, then re-enable; stored offset comes back
        @(negedge clk); align_en = 1'b0;
        idle(1);
        chk("R1 offset while disabled", int'(offset), 0);
        pulse_realign();
        frames(20, 1'b1);
        @(negedge clk); align_en = 1'b1;
        idle(1);
        chk("R4 offset retained", int'(offset), 2);
        // R9: enabling restarts the hold-off
        frames(15, 1'b1);
        idle(2);
        chk("R9 fresh hold-off", int'(offset), 2);
        @(negedge clk); align_en = 1'b0;
        @(negedge clk); align_en = 1'b1;

        // R6/R5: the limit of the error count
        frames(16, 1'b0);
        frames(4, 1'b1);
        idle(2);
        chk("R6 four errors", int'(offset), 2);
        frames(1, 1'b1);
        idle(1);
        chk("R5 fifth error", int'(offset), 3);

        // R6: an error that drops out of the window stops counting
        frames(16, 1'b0);
        frames(4, 1'b1);
        frames(12, 1'b0);
        frames(1, 1'b1);
        idle(2);
        chk("R6 sliding window", int'(offset), 3);
        send_byte(8'h99, 3'd3, "R2 final");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule